// File: doc/BRIEF.md
# Radio Pin Bank Controller with State-Driven Outputs

This block controls 32 general-purpose pads next to a radio front end. The low 16 pads form the receive bank and the high 16 pads form the transmit bank. Software reaches the block through a plain 32-bit register bus: a word address, a write strobe, write data and combinational read data. Through that bus it sets the level each pad drives, the pad direction, and the source that feeds each pad.

Each pad picks one of four sources. The first is the software data register. The second is a state table with one 32-bit word per radio state, chosen by the `tx_active` and `rx_active` inputs. The third and fourth are two debug buses. Designers route pads to the state table so that front-end switches and amplifier enables follow the transmit and receive state with no software involvement. Pad input levels pass through a two-stage synchronizer before software can read them.

Top module: `radio_pin_ctrl`

## Requirements
- R1: After a synchronous reset, every direction bit is 0 (all pads input), the data register and all four state-table words are 0, and every select field chooses the software source. As a result `pad_oe` and `pad_out` both read 0.
- R2: `pad_oe[i]` equals bit i of the direction register at word address 1, where 1 means output. A write takes effect after the write edge.
- R3: Pads 15:0 (receive bank) take their 2-bit select field from the register at word address 3, and pads 31:16 (transmit bank) from the register at word address 2. Bank pad k uses bits 2k+1:2k of its bank's register.
- R4: Select code 0 drives the pad from the matching bit of the data register at word address 0.
- R5: Select code 1 drives the pad from the matching bit of the current state-table word. The state index is {rx_active, tx_active}: 0 idle, 1 transmit only, 2 receive only, 3 both. The table words sit at word addresses 4 + index.
- R6: Select code 2 drives the pad from `dbg0_bus` and code 3 from `dbg1_bus`, with no register in between.
- R7: A change on `tx_active`/`rx_active` reaches pads on state-table select at the first rising edge that samples the new state, and not before.
- R8: A write to the data, direction, either select register, or the state-table word for the current state shows on the pads right after the edge that performs the write.
- R9: A read at word address 0 returns `pad_in` as it was sampled two rising edges earlier.
- R10: Reads at word addresses 1–7 return the last value written there. Word addresses 8–15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| dbg0_bus | input | 32 | Debug source 0 |
| dbg1_bus | input | 32 | Debug source 1 |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |

## Verification
Register writes and state-table selection land on the pads after a single rising edge. Debug-bus routing and register readback are combinational, so they are due in the same cycle as the stimulus. The synchronized pad levels appear on a data read two edges after the pads change. The bench drives every input one time step after a falling edge. Its behavioural model advances on each rising edge, and the next falling edge compares all outputs with the model. The directed state-transition checks also sample once before the rising edge, which confirms that the pads have not yet moved.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    localparam int PIN_N       = 32;
    localparam int BANK_W      = PIN_N / 2;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int ATR_N       = 4;
    localparam int SYNC_STAGES = 2;

    // word addresses
    localparam int A_DATA  = 0;
    localparam int A_DIR   = 1;
    localparam int A_TXSEL = 2;
    localparam int A_RXSEL = 3;
    localparam int A_ATR0  = 4;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2,
        ST_FULL = 2'd3
    } radio_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] sw_data;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] tx_sel;
        logic [WORD_W-1:0] rx_sel;
    } ctl_regs_t;

    function automatic radio_state_e state_of(input logic rx, input logic tx);
        return radio_state_e'({rx, tx});
    endfunction

endpackage

// File: rtl/pinctl_regs.sv
module pinctl_regs
    import pinctl_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int AW    = ADDR_W,
    parameter int TBL_N = ATR_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          tx_active,
    input  logic          rx_active,
    output ctl_regs_t     regs_q,
    output logic [W-1:0]  atr_q,
    output logic [W-1:0]  rd_word
);
    localparam int IDX_W = $clog2(TBL_N);

    logic [W-1:0]     tbl [TBL_N];
    radio_state_e     st;
    logic             atr_hit;
    logic [IDX_W-1:0] atr_wi;
    logic [IDX_W-1:0] st_idx;

    assign st      = state_of(rx_active, tx_active);
    assign st_idx  = IDX_W'(st);
    assign atr_hit = (int'(addr) >= A_ATR0) && (int'(addr) < A_ATR0 + TBL_N);
    assign atr_wi  = IDX_W'(int'(addr) - A_ATR0);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            atr_q  <= '0;
            for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
        end else begin
            if (we) begin
                case (int'(addr))
                    A_DATA:  regs_q.sw_data <= wdata;
                    A_DIR:   regs_q.dir     <= wdata;
                    A_TXSEL: regs_q.tx_sel  <= wdata;
                    A_RXSEL: regs_q.rx_sel  <= wdata;
                    default: ;
                endcase
            end
            for (int i = 0; i < TBL_N; i++) begin
                if (we && atr_hit && (atr_wi == IDX_W'(i))) tbl[i] <= wdata;
            end
            // forward a same-edge write to the word of the current state
            if (we && atr_hit && (atr_wi == st_idx)) atr_q <= wdata;
            else                                     atr_q <= tbl[st_idx];
        end
    end

    always_comb begin
        rd_word = '0;
        case (int'(addr))
            A_DIR:   rd_word = regs_q.dir;
            A_TXSEL: rd_word = regs_q.tx_sel;
            A_RXSEL: rd_word = regs_q.rx_sel;
            default: if (atr_hit) rd_word = tbl[atr_wi];
        endcase
    end

endmodule

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pinctl_route.sv
module pinctl_route
    import pinctl_pkg::*;
#(
    parameter int N  = PIN_N,
    parameter int BW = BANK_W
) (
    input  logic [N-1:0]    sw_data,
    input  logic [N-1:0]    atr_word,
    input  logic [N-1:0]    dbg0,
    input  logic [N-1:0]    dbg1,
    input  logic [2*BW-1:0] tx_sel,
    input  logic [2*BW-1:0] rx_sel,
    output logic [N-1:0]    pin_out
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        localparam int K = p % BW;
        pin_src_e src;
        if (p < BW) begin : g_rx
            assign src = pin_src_e'(rx_sel[2*K +: 2]);
        end else begin : g_tx
            assign src = pin_src_e'(tx_sel[2*K +: 2]);
        end
        always_comb begin
            case (src)
                SRC_SW:   pin_out[p] = sw_data[p];
                SRC_ATR:  pin_out[p] = atr_word[p];
                SRC_DBG0: pin_out[p] = dbg0[p];
                default:  pin_out[p] = dbg1[p];
            endcase
        end
    end

endmodule

// File: rtl/radio_pin_ctrl.sv
module radio_pin_ctrl
    import pinctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [PIN_N-1:0]  dbg0_bus,
    input  logic [PIN_N-1:0]  dbg1_bus,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe
);
    ctl_regs_t         regs;
    logic [WORD_W-1:0] atr_word;
    logic [WORD_W-1:0] rd_word;
    logic [PIN_N-1:0]  pin_sync;

    pinctl_regs #(.W(WORD_W), .AW(ADDR_W), .TBL_N(ATR_N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .regs_q    (regs),
        .atr_q     (atr_word),
        .rd_word   (rd_word)
    );

    pinctl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    pinctl_route #(.N(PIN_N), .BW(BANK_W)) u_route (
        .sw_data  (regs.sw_data),
        .atr_word (atr_word),
        .dbg0     (dbg0_bus),
        .dbg1     (dbg1_bus),
        .tx_sel   (regs.tx_sel),
        .rx_sel   (regs.rx_sel),
        .pin_out  (pad_out)
    );

    assign pad_oe    = regs.dir;
    assign bus_rdata = (int'(bus_addr) == A_DATA) ? pin_sync : rd_word;

endmodule

// File: rtl/pinctl_checker.sv
module pinctl_checker
    import pinctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [PIN_N-1:0]  pad_in,
    input logic [PIN_N-1:0]  pad_out,
    input logic [PIN_N-1:0]  pad_oe
);
    logic [1:0] since_rst;
    logic       prev_rst;

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (prev_rst === 1'b1 && rst === 1'b0) begin
            assert_reset_clear_R1: assert (pad_oe == '0 && pad_out == '0)
                else $error("pads not cleared after reset");
        end
    end

    assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && int'(bus_addr) == A_DIR) |=> (pad_oe == $past(bus_wdata)));

    assert_sync_depth_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && int'(bus_addr) == A_DATA) |-> (bus_rdata == $past(pad_in, 2)));

    assert_sel_readback_R10: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 0 && $past(bus_we) && int'($past(bus_addr)) == A_TXSEL
         && int'(bus_addr) == A_TXSEL) |-> (bus_rdata == $past(bus_wdata)));

endmodule

bind radio_pin_ctrl pinctl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/radio_pin_ctrl_test.sv
`timescale 1ns/1ps
module radio_pin_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic [31:0] dbg0_bus = '0;
    logic [31:0] dbg1_bus = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    radio_pin_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_active(tx_active), .rx_active(rx_active),
        .dbg0_bus(dbg0_bus), .dbg1_bus(dbg1_bus),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_data, m_dir, m_txs, m_rxs, m_atr, m_s1, m_s2;
    logic [31:0] m_tbl [4];

    always @(posedge clk) begin
        int idx;
        started <= 1'b1;
        idx = {rx_active, tx_active};
        if (rst) begin
            m_data <= 0; m_dir <= 0; m_txs <= 0; m_rxs <= 0; m_atr <= 0;
            m_s1 <= 0; m_s2 <= 0;
            for (int i = 0; i < 4; i++) m_tbl[i] <= 0;
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    4'd0: m_data <= bus_wdata;
                    4'd1: m_dir  <= bus_wdata;
                    4'd2: m_txs  <= bus_wdata;
                    4'd3: m_rxs  <= bus_wdata;
                    4'd4, 4'd5, 4'd6, 4'd7: m_tbl[bus_addr - 4] <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_we && int'(bus_addr) == 4 + idx) m_atr <= bus_wdata;
            else                                      m_atr <= m_tbl[idx];
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    function automatic logic [1:0] m_sel(input int p);
        if (p < 16) return m_rxs[2*p +: 2];
        return m_txs[2*(p-16) +: 2];
    endfunction

    function automatic logic [31:0] exp_out();
        logic [31:0] r;
        for (int p = 0; p < 32; p++) begin
            case (m_sel(p))
                2'd0: r[p] = m_data[p];
                2'd1: r[p] = m_atr[p];
                2'd2: r[p] = dbg0_bus[p];
                default: r[p] = dbg1_bus[p];
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd();
        case (bus_addr)
            4'd0: return m_s2;
            4'd1: return m_dir;
            4'd2: return m_txs;
            4'd3: return m_rxs;
            4'd4, 4'd5, 4'd6, 4'd7: return m_tbl[bus_addr - 4];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] e;
            string tag;
            chk("R2 pad_oe", pad_oe, m_dir);
            e = exp_out();
            tag = "R4 pad_out";
            for (int p = 31; p >= 0; p--) begin
                if (pad_out[p] !== e[p]) begin
                    case (m_sel(p))
                        2'd0: tag = "R4 pad_out sw";
                        2'd1: tag = "R5 pad_out table";
                        default: tag = "R6 pad_out debug";
                    endcase
                end
            end
            chk(tag, pad_out, e);
            chk((bus_addr == 0) ? "R9 sync read" : "R10 readback", bus_rdata, exp_rd());
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic step_in();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 oe after reset", pad_oe, 32'h0);
        chk("R1 out after reset", pad_out, 32'h0);
        bus_addr = 4'd1; #1;
        chk("R1 dir after reset", bus_rdata, 32'h0);

        // R4 / R8: software data and direction
        bus_write(4'd0, 32'hA5A5_3C3C);
        chk("R8 data after write", pad_out, 32'hA5A5_3C3C);
        bus_write(4'd1, 32'hFFFF_FFFF);
        chk("R8 dir after write", pad_oe, 32'hFFFF_FFFF);

        // R9 synchronizer depth
        bus_addr = 4'd0;
        pad_in = 32'h1357_9BDF;
        repeat (3) step_in();
        pad_in = 32'hFFFF_0000;
        repeat (3) step_in();

        // R3 / R6 bank split and debug routing
        dbg0_bus = 32'h1234_5678; dbg1_bus = 32'hEDCB_A987;
        bus_write(4'd2, 32'hAAAA_AAAA);
        chk("R3 tx bank from dbg0", pad_out, 32'h1234_3C3C);
        bus_write(4'd3, 32'h0000_0003);
        chk("R3 rx pin0 from dbg1", pad_out, 32'h1234_3C3D);
        bus_write(4'd2, 32'hFFFF_FFFF);
        bus_write(4'd3, 32'hE4E4_E4E4);
        dbg0_bus = 32'h0F0F_F0F0; step_in();
        dbg1_bus = 32'h3333_CCCC; step_in();

        // R5 / R7 state table
        bus_write(4'd4, 32'h1111_2222);
        bus_write(4'd5, 32'h3333_4444);
        bus_write(4'd6, 32'h5555_6666);
        bus_write(4'd7, 32'h7777_8888);
        bus_write(4'd2, 32'h5555_5555);
        bus_write(4'd3, 32'h5555_5555);
        chk("R5 idle word", pad_out, 32'h1111_2222);
        @(negedge clk); #1 tx_active = 1'b1; #1;
        chk("R7 not before edge", pad_out, 32'h1111_2222);
        @(negedge clk);
        chk("R7 tx-only word", pad_out, 32'h3333_4444);
        #1 rx_active = 1'b1;
        @(negedge clk);
        chk("R7 full word", pad_out, 32'h7777_8888);
        #1 tx_active = 1'b0;
        @(negedge clk);
        chk("R7 rx-only word", pad_out, 32'h5555_6666);
        bus_write(4'd6, 32'hDEAD_BEEF);
        chk("R8 table write forwarded", pad_out, 32'hDEAD_BEEF);

        // R10 unmapped write ignored, full readback sweep
        bus_write(4'd9, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) begin
            step_in(); bus_addr = 4'(a);
        end
        bus_addr = 4'd9; #1;
        chk("R10 unmapped reads zero", bus_rdata, 32'h0);
        bus_addr = 4'd5; #1;
        chk("R10 table word kept", bus_rdata, 32'h3333_4444);

        // R2 partial direction
        bus_write(4'd1, 32'h00F0_0F00);
        chk("R2 partial oe", pad_oe, 32'h00F0_0F00);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            step_in();
            bus_we    = ($urandom % 3) == 0;
            bus_addr  = 4'($urandom);
            bus_wdata = $urandom;
            dbg0_bus  = $urandom;
            dbg1_bus  = $urandom;
            pad_in    = $urandom;
            tx_active = 1'($urandom);
            rx_active = 1'($urandom);
        end
        step_in(); bus_we = 1'b0;

        // R1 reset in mid-run
        rst = 1'b1;
        repeat (2) step_in();
        rst = 1'b0;
        chk("R1 oe after second reset", pad_oe, 32'h0);
        bus_addr = 4'd7; #1;
        chk("R1 table cleared", bus_rdata, 32'h0);
        repeat (3) step_in();

        finish_run();
    end

endmodule